// File: doc/BRIEF.md
# Configuration Download Controller

This block fills a chip's internal configuration memory banks, one byte per transfer, while the chip sits in configuration mode. All transfers are paced by a slow download clock and a one-cycle sync pulse, both derived from the master clock by a divide-by-32 counter. Each transfer produces a registered write beat: a byte-write strobe, a bank select, a word address within the bank, a byte-lane index and the data byte. Memory words are two bytes wide by default, so a word takes two consecutive transfers.

Two load sources are supported. In host-addressed loading, an external host presents a 10-bit packed address and a data byte. The block samples both on the master-clock edge where the sync pulse is high. In self-addressed loading, the block walks a 13-bit byte counter. It drives the counter to an external non-volatile memory as a 3-bit extension plus a 10-bit address bus, and samples the returned byte at the end of each download period. It stops after a programmable final fetch address and raises a done flag.

A restart input, or leaving configuration mode, returns the divider, counters and done flag to their idle state.

Top module: `dl_loader`

## Requirements
- R1: While `cfg_mode` is low, `dl_clk` and `dl_sync` are low. No `wr_stb` pulse follows a cycle in which `cfg_mode` was low, and the self-address counter, lane counter and done flag are cleared.
- R2: With `cfg_mode` high and `restart` low, `dl_sync` is a one-cycle pulse every 32 master cycles. The first pulse is in the 32nd cycle after enabling. `dl_clk` is high for 16 of every 32 cycles, namely the second half of each period, which ends with the sync cycle.
- R3: In host mode (`auto_mode` low), the edge on which `dl_sync` is high captures `host_addr` and `din`. In the next cycle `wr_stb` is high for exactly one cycle, with `wr_bank` = `host_addr[9:7]`, `wr_word` = `host_addr[6:0]` and `wr_data` = the captured byte.
- R4: In host mode, `wr_lane` is 0 for the first write after enabling, restart or a mode change, and toggles on each later write (modulo 2 bytes per word).
- R5: In self mode the fetch address starts at 0 and rises by exactly 1 right after each capture edge. `fetch_hi` carries fetch bits [12:10] and `fetch_lo` carries bits [9:0]. In host mode both read 0.
- R6: In self mode, the byte captured at a sync edge with fetch address F is written with `wr_lane` = F[0], `wr_bank` = F[10:8] and `wr_word` = F[7:1].
- R7: In self mode, `load_done` rises in the cycle of the write for fetch address `last_fetch`. After that, the fetch address holds and no further `wr_stb` occurs until restart or configuration mode is left.
- R8: A `restart` pulse of one master cycle clears the fetch address, lane and done flag, and restarts the divider. The next `dl_sync` is in the 32nd cycle after `restart` falls.
- R9: An active-low `rst_n` immediately forces `dl_clk`, `dl_sync`, `wr_stb`, `load_done` and the fetch outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| restart | input | 1 | Synchronous loader restart |
| cfg_mode | input | 1 | High enables configuration loading |
| auto_mode | input | 1 | Low: host supplies addresses; high: self-addressed fetch |
| host_addr | input | 10 | Packed host address: bank in [9:7], word in [6:0] |
| din | input | 8 | Byte input from host or external memory |
| last_fetch | input | 13 | Final fetch address of a self-addressed load |
| fetch_hi | output | 3 | Upper extension of the fetch address (MSBs) |
| fetch_lo | output | 10 | Lower 10 bits of the fetch address |
| dl_clk | output | 1 | Download clock, master clock / 32 |
| dl_sync | output | 1 | One-cycle transfer pulse per download period |
| wr_stb | output | 1 | Byte-write strobe |
| wr_bank | output | 3 | Memory bank select |
| wr_word | output | 7 | Word address within the bank |
| wr_lane | output | 1 | Byte lane within the word |
| wr_data | output | 8 | Byte to write |
| load_done | output | 1 | Self-addressed load reached its final address |

## Verification
A divider that is out of phase shows up on the ports as a sync pulse that arrives early or late, within one 32-cycle period of enabling or restarting. A slipped fetch counter shows up as a fetch address that does not match the bench's count at the next sync. It also puts a wrong bank, word or lane on the very next write beat. A lane counter that is not cleared, or a done flag that is missed, shows up at the first host write after a mode change, or as a stray strobe in the period after the final address.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  localparam int unsigned DLC_DIV     = 32;
  localparam int unsigned DLC_ADDR_W  = 10;
  localparam int unsigned DLC_BANK_W  = 3;
  localparam int unsigned DLC_FETCH_W = 13;
  localparam int unsigned DLC_DATA_W  = 8;
  localparam int unsigned DLC_LANE_W  = 1;

  // source of the write address for a transfer
  typedef enum logic {
    SRC_HOST = 1'b0,
    SRC_SELF = 1'b1
  } load_src_e;
endpackage

// File: rtl/dlc_rst_sync.sv
module dlc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dlc_pacer.sv
module dlc_pacer #(
  parameter int unsigned DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic dl_clk,
  output logic dl_sync
);
  localparam int unsigned CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign dl_clk  = en && (cnt_q >= HALF);
  assign dl_sync = en && (cnt_q == LAST);
endmodule

// File: rtl/dlc_selfaddr.sv
module dlc_selfaddr #(
  parameter int unsigned FETCH_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic [FETCH_W-1:0] last,
  output logic [FETCH_W-1:0] fa,
  output logic               done,
  output logic               cap
);
  logic [FETCH_W-1:0] fa_q, fa_d;
  logic               done_q, done_d;
  logic               at_last;

  assign cap     = step && !done_q;
  assign at_last = (fa_q == last);

  always_comb begin
    fa_d   = fa_q;
    done_d = done_q;
    if (clr) begin
      fa_d   = '0;
      done_d = 1'b0;
    end else if (cap) begin
      if (at_last) done_d = 1'b1;
      else         fa_d   = fa_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q   <= '0;
      done_q <= 1'b0;
    end else begin
      fa_q   <= fa_d;
      done_q <= done_d;
    end
  end

  assign fa   = fa_q;
  assign done = done_q;
endmodule

// File: rtl/dlc_lane.sv
module dlc_lane #(
  parameter int unsigned LANE_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [LANE_W-1:0] lane
);
  logic [LANE_W-1:0] lane_q, lane_d;

  always_comb begin
    lane_d = lane_q;
    if (clr)       lane_d = '0;
    else if (step) lane_d = lane_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end

  assign lane = lane_q;
endmodule

// File: rtl/dlc_writer.sv
module dlc_writer
  import dlc_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANE_W = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap,
  input  load_src_e                src,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [LANE_W-1:0]        host_lane,
  input  logic [ADDR_W-1:0]        self_addr,
  input  logic [LANE_W-1:0]        self_lane,
  input  logic [DATA_W-1:0]        din,
  output logic                     wr_stb,
  output logic [BANK_W-1:0]        wr_bank,
  output logic [ADDR_W-BANK_W-1:0] wr_word,
  output logic [LANE_W-1:0]        wr_lane,
  output logic [DATA_W-1:0]        wr_data
);
  localparam int unsigned WORD_W = ADDR_W - BANK_W;

  logic [ADDR_W-1:0] addr_sel;
  logic [LANE_W-1:0] lane_sel;
  logic              stb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANE_W-1:0] lane_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    addr_sel = host_addr;
    lane_sel = host_lane;
    if (src == SRC_SELF) begin
      addr_sel = self_addr;
      lane_sel = self_lane;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= cap;
  end

  // beat fields load only on a capture edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      lane_q <= '0;
      data_q <= '0;
    end else if (cap) begin
      addr_q <= addr_sel;
      lane_q <= lane_sel;
      data_q <= din;
    end
  end

  assign wr_stb  = stb_q;
  assign wr_bank = addr_q[ADDR_W-1 -: BANK_W];
  assign wr_word = addr_q[WORD_W-1:0];
  assign wr_lane = lane_q;
  assign wr_data = data_q;
endmodule

// File: rtl/dl_loader.sv
module dl_loader
  import dlc_pkg::*;
#(
  parameter int unsigned DIV     = DLC_DIV,
  parameter int unsigned ADDR_W  = DLC_ADDR_W,
  parameter int unsigned BANK_W  = DLC_BANK_W,
  parameter int unsigned FETCH_W = DLC_FETCH_W,
  parameter int unsigned DATA_W  = DLC_DATA_W,
  parameter int unsigned LANE_W  = DLC_LANE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restart,
  input  logic                      cfg_mode,
  input  logic                      auto_mode,
  input  logic [ADDR_W-1:0]         host_addr,
  input  logic [DATA_W-1:0]         din,
  input  logic [FETCH_W-1:0]        last_fetch,
  output logic [FETCH_W-ADDR_W-1:0] fetch_hi,
  output logic [ADDR_W-1:0]         fetch_lo,
  output logic                      dl_clk,
  output logic                      dl_sync,
  output logic                      wr_stb,
  output logic [BANK_W-1:0]         wr_bank,
  output logic [ADDR_W-BANK_W-1:0]  wr_word,
  output logic [LANE_W-1:0]         wr_lane,
  output logic [DATA_W-1:0]         wr_data,
  output logic                      load_done
);
  localparam int unsigned EXT_W = FETCH_W - ADDR_W;

  logic               rst_n_int;
  logic               run_en;
  logic               self_clr, host_clr;
  logic               self_step, self_cap, host_cap, any_cap;
  logic [FETCH_W-1:0] fa;
  logic [LANE_W-1:0]  host_lane;
  load_src_e          src;

  dlc_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign run_en = cfg_mode && !restart;
  assign src    = load_src_e'(auto_mode);

  dlc_pacer #(.DIV(DIV)) i_pacer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (run_en),
    .dl_clk  (dl_clk),
    .dl_sync (dl_sync)
  );

  assign self_clr  = !run_en || (src != SRC_SELF);
  assign self_step = dl_sync && (src == SRC_SELF);

  dlc_selfaddr #(.FETCH_W(FETCH_W)) i_self (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (self_clr),
    .step  (self_step),
    .last  (last_fetch),
    .fa    (fa),
    .done  (load_done),
    .cap   (self_cap)
  );

  assign host_clr = !run_en || (src != SRC_HOST);
  assign host_cap = dl_sync && (src == SRC_HOST);

  dlc_lane #(.LANE_W(LANE_W)) i_lane (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (host_clr),
    .step  (host_cap),
    .lane  (host_lane)
  );

  assign any_cap = host_cap || self_cap;

  dlc_writer #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) i_writer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cap       (any_cap),
    .src       (src),
    .host_addr (host_addr),
    .host_lane (host_lane),
    .self_addr (fa[LANE_W +: ADDR_W]),
    .self_lane (fa[LANE_W-1:0]),
    .din       (din),
    .wr_stb    (wr_stb),
    .wr_bank   (wr_bank),
    .wr_word   (wr_word),
    .wr_lane   (wr_lane),
    .wr_data   (wr_data)
  );

  assign fetch_hi = fa[FETCH_W-1 -: EXT_W];
  assign fetch_lo = fa[ADDR_W-1:0];
endmodule

// File: rtl/dl_loader_chk.sv
module dl_loader_chk #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned FETCH_W = 13
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      restart,
  input logic                      cfg_mode,
  input logic                      auto_mode,
  input logic [FETCH_W-ADDR_W-1:0] fetch_hi,
  input logic [ADDR_W-1:0]         fetch_lo,
  input logic                      dl_clk,
  input logic                      dl_sync,
  input logic                      wr_stb,
  input logic                      load_done
);
  logic [FETCH_W-1:0] fetch;
  assign fetch = {fetch_hi, fetch_lo};

  assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |-> (!dl_clk && !dl_sync));

  assert_no_write_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_mode) |-> !wr_stb);

  assert_sync_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dl_sync |=> !dl_sync);

  assert_strobe_follows_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(dl_sync));

  assert_fetch_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((fetch != $past(fetch)) && $past(cfg_mode && auto_mode && !restart))
      |-> ($past(dl_sync) && (fetch == $past(fetch) + 1'b1)));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && cfg_mode && auto_mode && !restart) |=> load_done);

  assert_done_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && $past(load_done)) |-> !wr_stb);
endmodule

bind dl_loader dl_loader_chk #(.ADDR_W(ADDR_W), .FETCH_W(FETCH_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .cfg_mode  (cfg_mode),
  .auto_mode (auto_mode),
  .fetch_hi  (fetch_hi),
  .fetch_lo  (fetch_lo),
  .dl_clk    (dl_clk),
  .dl_sync   (dl_sync),
  .wr_stb    (wr_stb),
  .load_done (load_done)
);

// File: tb/test_dl_loader.sv
`timescale 1ns/1ps
module test_dl_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        cfg_mode = 1'b0;
  logic        auto_mode = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [7:0]  host_din = '0;
  logic [12:0] last_fetch = '0;
  logic [7:0]  din;
  logic [2:0]  fetch_hi;
  logic [9:0]  fetch_lo;
  logic        dl_clk, dl_sync, wr_stb, load_done;
  logic [2:0]  wr_bank;
  logic [6:0]  wr_word;
  logic [0:0]  wr_lane;
  logic [7:0]  wr_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  // behavioural external memory: data valid 10 cycles after address settles
  logic [12:0] mem_seen = '0;
  int          mem_age  = 0;
  logic [7:0]  mem_data;

  function automatic logic [7:0] romval(int k);
    return 8'((k * 37 + 11) ^ (k >> 8));
  endfunction

  always @(posedge clk) begin
    if ({fetch_hi, fetch_lo} != mem_seen) begin
      mem_seen <= {fetch_hi, fetch_lo};
      mem_age  <= 0;
    end else if (mem_age < 15) begin
      mem_age <= mem_age + 1;
    end
  end
  assign mem_data = (mem_age >= 10) ? romval(int'(mem_seen)) : 8'h00;
  assign din = auto_mode ? mem_data : host_din;

  dl_loader i_dl_loader (
    .clk(clk), .rst_n(rst_n), .restart(restart), .cfg_mode(cfg_mode),
    .auto_mode(auto_mode), .host_addr(host_addr), .din(din),
    .last_fetch(last_fetch), .fetch_hi(fetch_hi), .fetch_lo(fetch_lo),
    .dl_clk(dl_clk), .dl_sync(dl_sync), .wr_stb(wr_stb), .wr_bank(wr_bank),
    .wr_word(wr_word), .wr_lane(wr_lane), .wr_data(wr_data), .load_done(load_done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // returns number of negedges until dl_sync is seen high
  task automatic wait_sync(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!dl_sync);
  endtask

  // manual vectors: {host_addr, data}
  localparam logic [17:0] VEC [6] = '{
    {10'h000, 8'h3C}, {10'h000, 8'hC3}, {10'h3FF, 8'hFF},
    {10'h3FF, 8'h01}, {10'h181, 8'h5A}, {10'h181, 8'hA5}
  };

  initial begin
    int n, cnt_s, cnt_c, cnt_w;
    logic [12:0] held;

    // R9: reset state
    #1;
    check(!dl_clk && !dl_sync && !wr_stb && !load_done, "R9", "reset outputs",
          int'({dl_clk, dl_sync, wr_stb, load_done}), 0);
    check({fetch_hi, fetch_lo} == 13'd0, "R9", "reset fetch", int'({fetch_hi, fetch_lo}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: cfg_mode low keeps everything idle
    cnt_s = 0; cnt_c = 0; cnt_w = 0;
    repeat (70) begin
      @(negedge clk);
      cnt_s += int'(dl_sync); cnt_c += int'(dl_clk); cnt_w += int'(wr_stb);
    end
    check(cnt_s == 0 && cnt_c == 0 && cnt_w == 0, "R1", "idle activity",
          cnt_s + cnt_c + cnt_w, 0);

    // R2: pacing
    cfg_mode = 1'b1;
    wait_sync(n);
    check(n == 31, "R2", "first sync negedge", n, 31);
    wait_sync(n);
    check(n == 32, "R2", "sync period", n, 32);
    cnt_c = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      cnt_c += int'(dl_clk);
      if (i < 15) check(!dl_clk, "R2", "dl_clk first half", int'(dl_clk), 0);
    end
    check(cnt_c == 16, "R2", "dl_clk high cycles", cnt_c, 16);

    // restart to clear lane before the table
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;

    // R3/R4: manual vector table
    for (int v = 0; v < 6; v++) begin
      host_addr = VEC[v][17:8];
      host_din  = VEC[v][7:0];
      wait_sync(n);
      @(negedge clk);
      check(wr_stb, "R3", "manual strobe", int'(wr_stb), 1);
      check(wr_bank == VEC[v][17:15], "R3", "manual bank", int'(wr_bank), int'(VEC[v][17:15]));
      check(wr_word == VEC[v][14:8], "R3", "manual word", int'(wr_word), int'(VEC[v][14:8]));
      check(wr_data == VEC[v][7:0], "R3", "manual data", int'(wr_data), int'(VEC[v][7:0]));
      check(wr_lane == 1'(v % 2), "R4", "manual lane", int'(wr_lane), v % 2);
      check({fetch_hi, fetch_lo} == 13'd0, "R5", "fetch zero in host mode",
            int'({fetch_hi, fetch_lo}), 0);
      if (v == 0) begin
        @(negedge clk);
        check(!wr_stb, "R3", "strobe single cycle", int'(wr_stb), 0);
      end
    end

    // R1: leaving config mode mid-stream blocks writes
    cfg_mode = 1'b0;
    cnt_w = 0; cnt_s = 0;
    repeat (70) begin
      @(negedge clk);
      cnt_w += int'(wr_stb); cnt_s += int'(dl_sync);
    end
    check(cnt_w == 0 && cnt_s == 0, "R1", "writes while blocked", cnt_w + cnt_s, 0);
    cfg_mode = 1'b1;
    host_addr = 10'h2A5; host_din = 8'h77;
    wait_sync(n);
    check(n == 31, "R2", "sync after re-enable", n, 31);
    @(negedge clk);
    check(wr_stb && wr_lane == 1'b0, "R4", "lane cleared by exit", int'(wr_lane), 0);

    // R5/R6/R7: self-addressed load up to 1025
    auto_mode = 1'b1; last_fetch = 13'd1025; restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    for (int k = 0; k <= 1025; k++) begin
      wait_sync(n);
      check({fetch_hi, fetch_lo} == 13'(k), "R5", "fetch address", int'({fetch_hi, fetch_lo}), k);
      if (k == 1025) check(fetch_hi == 3'd1 && fetch_lo == 10'd1, "R5", "fetch split",
                           int'(fetch_hi), 1);
      @(negedge clk);
      check(wr_stb, "R6", "self strobe", int'(wr_stb), 1);
      check(wr_lane == 1'(k % 2), "R6", "self lane", int'(wr_lane), k % 2);
      check(wr_bank == 3'((k >> 8) & 7), "R6", "self bank", int'(wr_bank), (k >> 8) & 7);
      check(wr_word == 7'((k >> 1) & 127), "R6", "self word", int'(wr_word), (k >> 1) & 127);
      check(wr_data == romval(k), "R6", "self data", int'(wr_data), int'(romval(k)));
      check(load_done == (k == 1025), "R7", "done timing", int'(load_done), int'(k == 1025));
    end

    // R7: nothing after done
    held = {fetch_hi, fetch_lo};
    cnt_w = 0;
    repeat (70) begin
      @(negedge clk);
      cnt_w += int'(wr_stb);
    end
    check(cnt_w == 0, "R7", "writes after done", cnt_w, 0);
    check({fetch_hi, fetch_lo} == held, "R7", "fetch holds", int'({fetch_hi, fetch_lo}), int'(held));
    check(load_done, "R7", "done sticky", int'(load_done), 1);

    // R8: restart clears state
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    check({fetch_hi, fetch_lo} == 13'd0 && !load_done, "R8", "restart clears",
          int'({fetch_hi, fetch_lo}), 0);
    wait_sync(n);
    check(n == 31, "R8", "sync after restart", n, 31);
    @(negedge clk);
    check(wr_stb && wr_lane == 1'b0 && wr_data == romval(0), "R8", "first beat after restart",
          int'(wr_data), int'(romval(0)));

    // R9: asynchronous reset mid-run
    repeat (40) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check(!dl_clk && !dl_sync && !wr_stb && !load_done && {fetch_hi, fetch_lo} == 13'd0,
          "R9", "async reset", int'({fetch_hi, fetch_lo}), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog (R1..R9 run incomplete): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule